// File: doc/BRIEF.md
# Board Fault Latch with Status Lamps

This block gathers the error strobes raised by a board's datapath into one sticky status word and turns that word into two error lines. Every latched error, of either class, drives the crate-local error line. Only the severe class drives the system-wide line. The severe class covers loss of lock on the serial link receiver, loss of event synchronisation and FIFO overflow. These errors need a full resynchronisation to recover from. The non-severe strobes only reach the crate-local line.

A second word keeps the cause of the first error seen since software last emptied it. An INIT pulse does not disturb this word, so after a re-initialisation software can still learn what started the trouble. The status word is emptied by INIT or by a write-one-to-clear register write.

Three front-panel lamps are driven: green shows run, red shows the system error, and yellow shows the crate error. Each lamp turn-on is stretched to a programmable minimum, 100 ms at the nominal clock, so that one-cycle events can be seen. A run input that toggles like a clock therefore shows as a steady light.

Top module: `board_fault_latch`

## Requirements
- R1: After reset the status word, the shadow word, both error lines and all three lamps are zero.
- R2: A strobe on severe input bit k (bit 0 = lock loss, bit 1 = sync loss, bit 2 = FIFO overflow) sets status bit k at the next clock edge. The bit stays set with no further strobe, and it drives both the system error line and the crate error line high.
- R3: A strobe on non-severe input bit j sets status bit N_SEV+j and raises the crate error line. It leaves the system error line low.
- R4: A write to address 0 clears exactly the status bits whose write-data bit is 1. Bits written with 0 keep their value.
- R5: A strobe in the same cycle as a clear, whether by write or by INIT, wins: its status bit is set after that edge.
- R6: An INIT pulse clears the whole status word and leaves the shadow word unchanged.
- R7: While the shadow word is empty, the first cycle with any strobe loads that cycle's strobe vector into shadow bits NB-1:0 (same layout as the status word) and sets valid bit NB. Later strobes do not change it.
- R8: Any write to address 1 clears the shadow word, whatever the write data.
- R9: Read data is combinational. Address 0 returns the status word and address 1 returns the shadow word, with zeros above.
- R10: The lamps are registered one cycle behind their sources: green follows the run input, red follows the system error line, and yellow follows the crate error line.
- R11: A lamp whose source was high at a clock edge stays on for exactly HOLD_CYC cycles after the last edge at which the source was high.
- R12: A run input that toggles with a period shorter than HOLD_CYC keeps the green lamp steadily on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sev_stb_i | input | N_SEV | Severe error strobes |
| mild_stb_i | input | N_MILD | Non-severe error strobes |
| init_i | input | 1 | INIT pulse, clears the status word |
| run_i | input | 1 | Run status |
| wr_en_i | input | 1 | Register write enable |
| addr_i | input | 1 | Register select: 0 status, 1 shadow |
| wdata_i | input | DW | Register write data |
| rdata_o | output | DW | Register read data |
| local_err_o | output | 1 | Crate-local error line |
| sys_err_o | output | 1 | System-wide error line |
| led_run_o | output | 1 | Green lamp |
| led_sys_o | output | 1 | Red lamp |
| led_local_o | output | 1 | Yellow lamp |

## Verification
A wrong status bit shows at once: the error lines and the address-0 read value change in the cycle after the strobe, clear or INIT edge. The lamps show the same fault one cycle later. A shadow fault shows only when address 1 is read, so every scenario reads the shadow back after INIT, after later strobes and after its own clear. A miscounted stretch shows only at the end of the hold window, so the lamp is sampled on both sides of the HOLD_CYC boundary.

// File: rtl/board_fault_latch.sv
module board_fault_latch #(
  parameter int N_SEV    = 3,
  parameter int N_MILD   = 4,
  parameter int DW       = 16,
  parameter int HOLD_CYC = 25_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SEV-1:0]  sev_stb_i,
  input  logic [N_MILD-1:0] mild_stb_i,
  input  logic              init_i,
  input  logic              run_i,
  input  logic              wr_en_i,
  input  logic              addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              local_err_o,
  output logic              sys_err_o,
  output logic              led_run_o,
  output logic              led_sys_o,
  output logic              led_local_o
);
  localparam int NB = N_SEV + N_MILD;
  localparam int CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] RELOAD = CW'(HOLD_CYC - 1);

  logic [NB-1:0] stat_q, cause_q;
  logic          cause_v_q;

  wire [NB-1:0] hit      = {mild_stb_i, sev_stb_i};
  wire          stat_wr  = wr_en_i && !addr_i;
  wire          shad_wr  = wr_en_i && addr_i;
  wire [NB-1:0] clr_mask = init_i ? {NB{1'b1}} : (stat_wr ? wdata_i[NB-1:0] : '0);
  wire          keep_v   = cause_v_q && !shad_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~clr_mask) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q   <= '0;
      cause_v_q <= 1'b0;
    end else begin
      if (shad_wr) begin
        cause_q   <= '0;
        cause_v_q <= 1'b0;
      end
      if (!keep_v && |hit) begin
        cause_q   <= hit;
        cause_v_q <= 1'b1;
      end
    end
  end

  assign sys_err_o   = |stat_q[N_SEV-1:0];
  assign local_err_o = |stat_q;
  assign rdata_o     = addr_i ? DW'({cause_v_q, cause_q}) : DW'(stat_q);

  wire  [2:0] led_src = {local_err_o, sys_err_o, run_i};
  logic [2:0] led_q;

  for (genvar i = 0; i < 3; i++) begin : g_lamp
    logic [CW-1:0] cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q    <= '0;
        led_q[i] <= 1'b0;
      end else if (led_src[i]) begin
        cnt_q    <= RELOAD;
        led_q[i] <= 1'b1;
      end else if (cnt_q != '0) begin
        cnt_q    <= cnt_q - 1'b1;
      end else begin
        led_q[i] <= 1'b0;
      end
    end

    // R10
    lamp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      led_src[i] |=> led_q[i]);
  end

  assign led_run_o   = led_q[0];
  assign led_sys_o   = led_q[1];
  assign led_local_o = led_q[2];

  // R2
  sev_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |sev_stb_i |=> (sys_err_o && local_err_o));

  // R3
  sys_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_err_o) |-> $past(|sev_stb_i));

  // R4
  full_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && &wdata_i[NB-1:0] && !(|hit)) |=> !local_err_o);

  // R5
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |=> local_err_o);

  // R6
  init_keeps_shadow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (init_i && !shad_wr && cause_v_q) |=> (cause_v_q && $stable(cause_q)));

  // R7
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_v_q && !shad_wr) |=> $stable(cause_q));
endmodule

// File: tb/board_fault_latch_test.sv
module board_fault_latch_test;
  localparam int NS = 3, NM = 4, DW = 16, HOLD = 8, NB = NS + NM;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NS-1:0] sev = '0;
  logic [NM-1:0] mild = '0;
  logic init = 1'b0, run = 1'b0, wr_en = 1'b0, addr = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic local_err, sys_err, led_run, led_sys, led_local;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  board_fault_latch #(.N_SEV(NS), .N_MILD(NM), .DW(DW), .HOLD_CYC(HOLD)) uut (
    .clk(clk), .rst_n(rst_n), .sev_stb_i(sev), .mild_stb_i(mild), .init_i(init),
    .run_i(run), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .local_err_o(local_err), .sys_err_o(sys_err), .led_run_o(led_run),
    .led_sys_o(led_sys), .led_local_o(led_local));

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(logic a, output logic [DW-1:0] v);
    addr = a; #1; v = rdata; addr = 1'b0;
  endtask

  task automatic wr(logic a, logic [DW-1:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    tick();
    wr_en = 1'b0; addr = 1'b0; wdata = '0;
  endtask

  task automatic pulse(logic [NS-1:0] s, logic [NM-1:0] m);
    sev = s; mild = m;
    tick();
    sev = '0; mild = '0;
  endtask

  task automatic wipe();
    wr(1'b0, '1);
    wr(1'b1, '0);
    repeat (HOLD + 2) tick();
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    rd(1'b0, v); chk("R1 status", v, 0);
    rd(1'b1, v); chk("R1 shadow", v, 0);
    chk("R1 lines", {sys_err, local_err}, 0);
    chk("R1 lamps", {led_run, led_sys, led_local}, 0);
  endtask

  task automatic t_severe();
    logic [DW-1:0] v;
    for (int k = 0; k < NS; k++) begin
      pulse(NS'(1 << k), '0);
      chk("R2 sys line", sys_err, 1);
      chk("R2 crate line", local_err, 1);
      repeat (3) tick();
      rd(1'b0, v); chk("R2 sticky bit", v, 1 << k);
      wr(1'b0, DW'(1 << k));
      rd(1'b0, v); chk("R4 clear severe", v, 0);
      chk("R4 sys line low", sys_err, 0);
    end
  endtask

  task automatic t_mild();
    logic [DW-1:0] v;
    wipe();
    for (int j = 0; j < NM; j++) begin
      pulse('0, NM'(1 << j));
      chk("R3 crate line", local_err, 1);
      chk("R3 sys line stays low", sys_err, 0);
      rd(1'b0, v); chk("R3 bit position", v, 1 << (NS + j));
      wr(1'b0, DW'(1 << (NS + j)));
    end
    pulse('0, 4'b0101);
    wr(1'b0, DW'(1 << NS));
    rd(1'b0, v); chk("R4 partial clear", v, 1 << (NS + 2));
    wr(1'b0, '1);
    rd(1'b0, v); chk("R4 full clear", v, 0);
  endtask

  task automatic t_collide();
    logic [DW-1:0] v;
    pulse(3'b001, '0);
    sev = 3'b001;
    wr(1'b0, DW'(1));
    sev = '0;
    rd(1'b0, v); chk("R5 set beats write clear", v, 1);
    init = 1'b1; mild = 4'b0010;
    tick();
    init = 1'b0; mild = '0;
    rd(1'b0, v); chk("R5 set beats INIT", v, 1 << (NS + 1));
    wr(1'b0, '1);
  endtask

  task automatic t_init();
    logic [DW-1:0] v;
    wr(1'b1, '0);
    pulse(3'b100, '0);
    pulse('0, 4'b0001);
    rd(1'b0, v); chk("R6 before INIT", v, (1 << 2) | (1 << NS));
    init = 1'b1; tick(); init = 1'b0;
    rd(1'b0, v); chk("R6 INIT clears status", v, 0);
    chk("R6 lines low", {sys_err, local_err}, 0);
    rd(1'b1, v); chk("R6 shadow survives", v, (1 << NB) | (1 << 2));
  endtask

  task automatic t_shadow();
    logic [DW-1:0] v;
    wr(1'b1, 16'h1234);
    rd(1'b1, v); chk("R8 shadow cleared", v, 0);
    pulse(3'b010, 4'b1000);
    rd(1'b1, v); chk("R7 first cause", v, (1 << NB) | (1 << 1) | (1 << (NS + 3)));
    pulse(3'b001, '0);
    rd(1'b1, v); chk("R7 later cause ignored", v, (1 << NB) | (1 << 1) | (1 << (NS + 3)));
    rd(1'b0, v); chk("R9 status read", v, (1 << 0) | (1 << 1) | (1 << (NS + 3)));
    wr(1'b1, '0);
    rd(1'b1, v); chk("R8 cleared again", v, 0);
    pulse('0, 4'b0100);
    rd(1'b1, v); chk("R7 recapture", v, (1 << NB) | (1 << (NS + 2)));
    wr(1'b0, '1);
  endtask

  task automatic t_lamps();
    wipe();
    pulse(3'b001, '0);
    chk("R10 red not yet", led_sys, 0);
    tick();
    chk("R10 red on", led_sys, 1);
    chk("R10 yellow on", led_local, 1);
    chk("R10 green off", led_run, 0);
    wr(1'b0, '1);
    chk("R11 red held after clear", {sys_err, led_sys}, 2'b01);
    wipe();
    pulse('0, 4'b0001);
    tick();
    chk("R10 yellow only", {led_sys, led_local}, 2'b01);
    wipe();
    pulse('0, '0);
    run = 1'b1; tick(); run = 1'b0;
    chk("R11 green on", led_run, 1);
    repeat (HOLD - 1) tick();
    chk("R11 green at hold end", led_run, 1);
    tick();
    chk("R11 green off after hold", led_run, 0);
  endtask

  task automatic t_blink();
    int bad = 0;
    for (int c = 0; c < 60; c++) begin
      run = ((c / 3) % 2) == 0;
      tick();
      if (!led_run) bad++;
    end
    run = 1'b0;
    chk("R12 steady green", bad, 0);
  endtask

  initial begin
    #800000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    t_reset();
    t_severe();
    t_mild();
    t_collide();
    t_init();
    t_shadow();
    t_lamps();
    t_blink();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule